// File: doc/BRIEF.md
# Pointer-Addressed Two-Wire Register Slave

This block is the serial front end of a hardware-monitor register space. It watches an open-drain two-wire bus (SCL/SDA) from the system clock domain and answers one 7-bit slave address. Every access goes through an 8-bit pointer. A host write sends the slave address, then a pointer byte, then at most one data byte. A host read returns the byte at the pointer currently held. A pointer write followed by a repeated start and a read gives a random read. The slave never stretches the clock and never advances the pointer on its own.

The slave address is formed from a five-bit programmable prefix and the two address-select pins. The prefix resets to 01011 and the host can rewrite it through a register. The two pins always supply the low address bits. The block also holds the control registers with their reset values, two fixed identification bytes, and two read-only views of the five processor voltage-identification pins.

Top module: `twi_reg_slave`

## Requirements
- R1: The slave acknowledges, by pulling SDA low during the ninth clock, an address byte whose upper seven bits (sent MSB first) equal the current slave address. Bit 0 of the address byte is 1 for a read. An address byte with any other value gets no acknowledge, and the slave leaves SDA released until the next START.
- R2: A write to location 0x48 loads data bits [6:2] into the address prefix. Bits [1:0] of the slave address always follow addr_pin[1:0]. Reading 0x48 returns {0, prefix, addr_pin}.
- R3: A write transaction (address with R/W=0, pointer byte, data byte) acknowledges every byte. It stores the data byte at the pointer location when that location is writable: 0x19, 0x40 to 0x44, 0x46 or 0x4B.
- R4: A read that is not preceded by a pointer write returns the register at the pointer already held. When the host acknowledges a read byte, the same location is sent again, because the pointer does not increment.
- R5: A pointer write followed by a repeated START and a read address returns the byte at the new pointer.
- R6: After reset, the registers read 0x40=0x08, 0x41 to 0x44=0x00, 0x46=0x00, 0x4B=0x01 and 0x19=0xFF, and the prefix is 01011.
- R7: Location 0x3E reads 0xDA and location 0x3F reads 0x01. Writes to these locations are acknowledged and have no effect.
- R8: Location 0x47 reads {0101, vid_pin[3:0]}. Location 0x49 reads {1000000, vid_pin[4]}.
- R9: sda_oe is the only SDA drive and it pulls the line low. It changes state only while SCL is low, and it is inactive after reset.
- R10: A data byte that follows the first data byte of a write gets no acknowledge and is not stored. A STOP releases SDA.
- R11: Locations that are not listed above read 0x00, and writes to them are acknowledged and ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; bus lines are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_pin | input | 2 | Address-select pins, low two slave address bits |
| vid_pin | input | 5 | Voltage-identification pin levels |

## Verification
The embedded assertions check, on every cycle, several properties of the bus engine and the register file. The data line is only ever grabbed while the clock line is low. An acknowledge during the address phase implies that the received address matched. The pointer holds still throughout a read. The slave stays silent after a non-matching address or after a surplus data byte, and it releases SDA after a STOP. The registers carry their defaults out of reset, a write lands in the addressed register, and a write to the identification location disturbs nothing. What the bench's bus scenarios alone can show is the end-to-end byte flow. This covers the values read back after each kind of write, the pointer surviving between transactions, a prefix rewrite moving the slave to a new address, pin changes reaching both the address and the identification views, and a mid-run reset restoring the defaults.

// File: rtl/twi_regs_pkg.sv
`timescale 1ns/1ps
package twi_regs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_PTR, ST_DATA, ST_READ, ST_SKIP
  } twi_state_e;

  // Writable byte registers held in the bank
  localparam int NUM_RW = 8;

  localparam logic [7:0] LOC_SADDR = 8'h48;
  localparam logic [7:0] LOC_ID    = 8'h3E;
  localparam logic [7:0] LOC_REV   = 8'h3F;
  localparam logic [7:0] LOC_VIDLO = 8'h47;
  localparam logic [7:0] LOC_VIDHI = 8'h49;

  function automatic logic [7:0] rw_loc(input int idx);
    case (idx)
      0: return 8'h40;
      1: return 8'h41;
      2: return 8'h42;
      3: return 8'h43;
      4: return 8'h44;
      5: return 8'h46;
      6: return 8'h4B;
      7: return 8'h19;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] rw_init(input int idx);
    case (idx)
      0: return 8'h08;
      6: return 8'h01;
      7: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [6:0] form_slave_addr(input logic [4:0] hi, input logic [1:0] pins);
    return {hi, pins};
  endfunction

  function automatic logic [7:0] pack_vid_lo(input logic [3:0] v);
    return {4'b0101, v};
  endfunction

  function automatic logic [7:0] pack_vid_hi(input logic v);
    return {7'b1000000, v};
  endfunction

endpackage

// File: rtl/twi_line_sync.sv
`timescale 1ns/1ps
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] pipe_q;
  logic            prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= {pipe_q[STAGES-1:0], raw};
  end

  assign lvl  = pipe_q[STAGES-1];
  assign prev = pipe_q[STAGES];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/twi_reg_bank.sv
`timescale 1ns/1ps
module twi_reg_bank
  import twi_regs_pkg::*;
#(
  parameter logic [4:0] ADDR_PREFIX = 5'b01011,
  parameter logic [7:0] ID_CODE     = 8'hDA,
  parameter logic [7:0] REV_CODE    = 8'h01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic [7:0] wr_loc,
  input  logic [7:0] wr_byte,
  input  logic [7:0] rd_loc,
  input  logic [1:0] addr_pin,
  input  logic [4:0] vid_pin,
  output logic [7:0] rd_byte,
  output logic [6:0] my_addr
);
  logic [NUM_RW-1:0][7:0] rw_vals;
  logic [NUM_RW-1:0]      rw_hit;
  logic [4:0]             sa_hi_q;

  for (genvar gi = 0; gi < NUM_RW; gi++) begin : g_rw
    logic [7:0] val_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               val_q <= rw_init(gi);
      else if (wr_stb && wr_loc == rw_loc(gi))  val_q <= wr_byte;
    end
    assign rw_vals[gi] = val_q;
    assign rw_hit[gi]  = (rd_loc == rw_loc(gi));

    // R6: each register leaves reset at its default
    p_rw_default_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> val_q == rw_init(gi));
    // R3: a strobed write lands in the addressed register
    p_rw_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && wr_loc == rw_loc(gi)) |=> val_q == $past(wr_byte));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               sa_hi_q <= ADDR_PREFIX;
    else if (wr_stb && wr_loc == LOC_SADDR)   sa_hi_q <= wr_byte[6:2];
  end

  assign my_addr = form_slave_addr(sa_hi_q, addr_pin);

  always_comb begin
    rd_byte = 8'h00;
    for (int i = 0; i < NUM_RW; i++)
      if (rw_hit[i]) rd_byte = rw_vals[i];
    case (rd_loc)
      LOC_SADDR: rd_byte = {1'b0, sa_hi_q, addr_pin};
      LOC_ID:    rd_byte = ID_CODE;
      LOC_REV:   rd_byte = REV_CODE;
      LOC_VIDLO: rd_byte = pack_vid_lo(vid_pin[3:0]);
      LOC_VIDHI: rd_byte = pack_vid_hi(vid_pin[4]);
      default:   ;
    endcase
  end

  // R7: a write to the identification location disturbs no register
  p_ro_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_loc == LOC_ID) |=> ($stable(rw_vals) && $stable(sa_hi_q)));
  // R6: prefix leaves reset at its default
  p_prefix_default_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> sa_hi_q == ADDR_PREFIX);
endmodule

// File: rtl/twi_frame_fsm.sv
`timescale 1ns/1ps
module twi_frame_fsm
  import twi_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_lvl,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_lvl,
  input  logic       sda_rise,
  input  logic       sda_fall,
  input  logic [6:0] my_addr,
  input  logic [7:0] rd_byte,
  output logic [7:0] ptr,
  output logic       wr_stb,
  output logic [7:0] wr_byte,
  output logic       sda_oe
);
  twi_state_e state_q;
  logic [3:0] cnt_q;
  logic [7:0] sh_q, tx_q, ptr_q;
  logic       rd_q, mack_q, oe_q, wr_stb_q;

  logic start_evt, stop_evt, active, addr_hit;
  assign start_evt = sda_fall & scl_lvl;
  assign stop_evt  = sda_rise & scl_lvl;
  assign active    = (state_q == ST_ADDR) || (state_q == ST_PTR) ||
                     (state_q == ST_DATA) || (state_q == ST_READ);
  assign addr_hit  = (sh_q[7:1] == my_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      tx_q     <= '0;
      ptr_q    <= '0;
      rd_q     <= 1'b0;
      mack_q   <= 1'b0;
      oe_q     <= 1'b0;
      wr_stb_q <= 1'b0;
    end else begin
      wr_stb_q <= 1'b0;
      if (start_evt) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else if (stop_evt) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else if (active) begin
        if (scl_rise) begin
          if (cnt_q < 4'd8)  sh_q   <= {sh_q[6:0], sda_lvl};
          if (cnt_q == 4'd8) mack_q <= ~sda_lvl;
          cnt_q <= cnt_q + 4'd1;
        end else if (scl_fall) begin
          if (cnt_q == 4'd8) begin
            case (state_q)
              ST_ADDR: if (addr_hit) begin
                         oe_q <= 1'b1;
                         rd_q <= sh_q[0];
                       end else begin
                         state_q <= ST_SKIP;
                       end
              ST_PTR:  begin oe_q <= 1'b1; ptr_q <= sh_q; end
              ST_DATA: begin oe_q <= 1'b1; wr_stb_q <= 1'b1; end
              default: oe_q <= 1'b0;
            endcase
          end else if (cnt_q == 4'd9) begin
            cnt_q <= '0;
            case (state_q)
              ST_ADDR: if (rd_q) begin
                         state_q <= ST_READ;
                         tx_q    <= rd_byte;
                         oe_q    <= ~rd_byte[7];
                       end else begin
                         state_q <= ST_PTR;
                         oe_q    <= 1'b0;
                       end
              ST_PTR:  begin state_q <= ST_DATA; oe_q <= 1'b0; end
              ST_DATA: begin state_q <= ST_SKIP; oe_q <= 1'b0; end
              default: if (mack_q) begin
                         tx_q <= rd_byte;
                         oe_q <= ~rd_byte[7];
                       end else begin
                         state_q <= ST_SKIP;
                         oe_q    <= 1'b0;
                       end
            endcase
          end else if (state_q == ST_READ && cnt_q != 4'd0) begin
            oe_q <= ~tx_q[3'd7 - cnt_q[2:0]];
          end
        end
      end
    end
  end

  assign ptr     = ptr_q;
  assign wr_stb  = wr_stb_q;
  assign wr_byte = sh_q;
  assign sda_oe  = oe_q;

  // R9: the data line is grabbed only while the clock line is low
  p_grab_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> !scl_lvl);
  // R1: an acknowledge in the address phase implies a matching address
  p_ack_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR && oe_q) |-> sh_q[7:1] == my_addr);
  // R10: nothing is driven while ignoring the rest of a transfer
  p_skip_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SKIP) |-> !oe_q);
  // R10: a STOP releases the line
  p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !oe_q);
  // R4: the pointer holds during a read
  p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READ) |-> $stable(ptr_q));
endmodule

// File: rtl/twi_reg_slave.sv
`timescale 1ns/1ps
module twi_reg_slave #(
  parameter logic [4:0] ADDR_PREFIX = 5'b01011,
  parameter logic [7:0] ID_CODE     = 8'hDA,
  parameter logic [7:0] REV_CODE    = 8'h01,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [1:0] addr_pin,
  input  logic [4:0] vid_pin
);
  logic       scl_lvl, scl_rise, scl_fall;
  logic       sda_lvl, sda_rise, sda_fall;
  logic [7:0] ptr, wr_byte, rd_byte;
  logic       wr_stb;
  logic [6:0] my_addr;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .raw(scl_i),
    .lvl(scl_lvl), .rise(scl_rise), .fall(scl_fall));

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .raw(sda_i),
    .lvl(sda_lvl), .rise(sda_rise), .fall(sda_fall));

  twi_frame_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
    .my_addr(my_addr), .rd_byte(rd_byte),
    .ptr(ptr), .wr_stb(wr_stb), .wr_byte(wr_byte), .sda_oe(sda_oe));

  twi_reg_bank #(
    .ADDR_PREFIX(ADDR_PREFIX), .ID_CODE(ID_CODE), .REV_CODE(REV_CODE)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_stb(wr_stb), .wr_loc(ptr), .wr_byte(wr_byte), .rd_loc(ptr),
    .addr_pin(addr_pin), .vid_pin(vid_pin),
    .rd_byte(rd_byte), .my_addr(my_addr));
endmodule

// File: tb/twi_reg_slave_test.sv
`timescale 1ns/1ps
module twi_reg_slave_test;
  localparam int Q = 100;   // quarter bit period, ns

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl_low = 1'b0;
  logic       m_sda_low = 1'b0;
  logic [1:0] apin = 2'b10;
  logic [4:0] vpin = 5'b10110;
  logic       sda_oe;
  logic       scl_line, sda_line;
  logic [6:0] dev = 7'h2E;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done  = 1'b0;

  always #5 clk = ~clk;

  assign scl_line = ~m_scl_low;
  assign sda_line = ~(m_sda_low | sda_oe);

  twi_reg_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .sda_oe(sda_oe), .addr_pin(apin), .vid_pin(vpin));

  // op[21:20]: 0 write, 1 random read, 2 current read; req[19:16]; ptr; value
  localparam int NV = 19;
  localparam logic [21:0] VEC [NV] = '{
    {2'd1, 4'd6, 8'h40, 8'h08}, {2'd1, 4'd6, 8'h41, 8'h00},
    {2'd1, 4'd6, 8'h4B, 8'h01}, {2'd1, 4'd6, 8'h19, 8'hFF},
    {2'd1, 4'd7, 8'h3E, 8'hDA}, {2'd1, 4'd7, 8'h3F, 8'h01},
    {2'd1, 4'd8, 8'h47, 8'h56}, {2'd1, 4'd8, 8'h49, 8'h81},
    {2'd1, 4'd2, 8'h48, 8'h2E},
    {2'd0, 4'd3, 8'h41, 8'hA5}, {2'd1, 4'd5, 8'h41, 8'hA5},
    {2'd2, 4'd4, 8'h00, 8'hA5},
    {2'd0, 4'd3, 8'h19, 8'h3C}, {2'd1, 4'd5, 8'h19, 8'h3C},
    {2'd0, 4'd7, 8'h3E, 8'h00}, {2'd1, 4'd7, 8'h3E, 8'hDA},
    {2'd0, 4'd3, 8'h46, 8'h7E}, {2'd2, 4'd4, 8'h00, 8'h7E},
    {2'd0, 4'd11, 8'h60, 8'h55}
  };

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd1: return "R1";   4'd2: return "R2";  4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";  4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";  4'd9: return "R9";
      4'd10: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic bus_start;
    m_sda_low = 1'b0; #Q; m_scl_low = 1'b0; #Q;
    m_sda_low = 1'b1; #Q; m_scl_low = 1'b1; #Q;
  endtask

  task automatic bus_stop;
    m_sda_low = 1'b1; #Q; m_scl_low = 1'b0; #Q; m_sda_low = 1'b0; #Q;
  endtask

  task automatic put_bit(input logic b);
    m_sda_low = ~b; #Q; m_scl_low = 1'b0; #(2*Q); m_scl_low = 1'b1; #Q;
  endtask

  task automatic get_bit(output logic b);
    m_sda_low = 1'b0; #Q; m_scl_low = 1'b0; #Q; b = sda_line; #Q;
    m_scl_low = 1'b1; #Q;
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(x);
    ack = ~x;
  endtask

  task automatic get_byte(input logic master_ack, output logic [7:0] v);
    logic x;
    for (int i = 7; i >= 0; i--) begin get_bit(x); v[i] = x; end
    put_bit(~master_ack);
  endtask

  task automatic reg_write(input logic [7:0] p, input logic [7:0] d, input string req);
    logic a;
    bus_start;
    put_byte({dev, 1'b0}, a); check(req, "write addr ack", {7'd0, a}, 8'h01);
    put_byte(p, a);           check(req, "pointer ack",    {7'd0, a}, 8'h01);
    put_byte(d, a);           check(req, "data ack",       {7'd0, a}, 8'h01);
    bus_stop;
  endtask

  task automatic reg_read_rand(input logic [7:0] p, input logic [7:0] exp, input string req);
    logic a;
    logic [7:0] v;
    bus_start;
    put_byte({dev, 1'b0}, a);
    put_byte(p, a);
    bus_start;
    put_byte({dev, 1'b1}, a); check(req, "read addr ack", {7'd0, a}, 8'h01);
    get_byte(1'b0, v);        check(req, $sformatf("random read %02h", p), v, exp);
    bus_stop;
  endtask

  task automatic reg_read_cur(input logic [7:0] exp, input string req);
    logic a;
    logic [7:0] v;
    bus_start;
    put_byte({dev, 1'b1}, a);
    get_byte(1'b0, v);        check(req, "current read", v, exp);
    bus_stop;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic a;
    logic [7:0] v1, v2;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9", "sda released after reset", {7'd0, sda_oe}, 8'h00);

    // table walk
    for (int k = 0; k < NV; k++) begin
      case (VEC[k][21:20])
        2'd0:    reg_write(VEC[k][15:8], VEC[k][7:0], req_name(VEC[k][19:16]));
        2'd1:    reg_read_rand(VEC[k][15:8], VEC[k][7:0], req_name(VEC[k][19:16]));
        default: reg_read_cur(VEC[k][7:0], req_name(VEC[k][19:16]));
      endcase
    end
    reg_read_rand(8'h60, 8'h00, "R11");

    // R1: foreign address is not acknowledged
    bus_start;
    put_byte({7'h50, 1'b0}, a);
    check("R1", "foreign address nack", {7'd0, a}, 8'h00);
    bus_stop;
    check("R10", "released after stop", {7'd0, sda_oe}, 8'h00);

    // R10: surplus data byte
    bus_start;
    put_byte({dev, 1'b0}, a);
    put_byte(8'h42, a);
    put_byte(8'h11, a); check("R3", "first data ack", {7'd0, a}, 8'h01);
    put_byte(8'h22, a); check("R10", "second data nack", {7'd0, a}, 8'h00);
    bus_stop;
    reg_read_rand(8'h42, 8'h11, "R10");

    // R4: acknowledged read repeats the same location
    bus_start;
    put_byte({dev, 1'b1}, a);
    get_byte(1'b1, v1);
    get_byte(1'b0, v2);
    bus_stop;
    check("R4", "first byte", v1, 8'h11);
    check("R4", "repeat byte, no increment", v2, 8'h11);

    // R8: pin changes reach the identification views
    vpin = 5'b01001;
    reg_read_rand(8'h47, 8'h59, "R8");
    reg_read_rand(8'h49, 8'h80, "R8");

    // R2: prefix rewrite and pin tracking
    reg_write(8'h48, 8'h54, "R2");
    bus_start;
    put_byte({7'h2E, 1'b0}, a);
    check("R2", "old address nack", {7'd0, a}, 8'h00);
    bus_stop;
    dev = 7'h56;
    reg_read_rand(8'h48, 8'h56, "R2");
    apin = 2'b01;
    dev  = 7'h55;
    reg_read_cur(8'h55, "R2");

    // R6: reset mid-run restores defaults
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    dev = 7'h2D;
    reg_read_rand(8'h41, 8'h00, "R6");
    reg_read_rand(8'h19, 8'hFF, "R6");
    reg_read_rand(8'h48, 8'h2D, "R6");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule